// File: doc/BRIEF.md
# Display panel power sequencer

This block brings a multi-rail LCD panel's timing generator up and down by issuing an ordered list of 8-bit register writes on a valid/ready write port with a 3-bit address. Between any two steps it waits a programmable number of clock cycles. One step of each sequence is not a register write. It loads the common-voltage bias DAC instead, through a request/done handshake that carries a base byte and a value byte.

The power-up sequence starts with `up_cmd`. At that moment the block captures the display mode (full or quarter resolution), a 4-bit phase value with its valid flag, and the 8-bit common-voltage setting. The phase byte, the DAC value and the final resolution byte are all derived from these captured inputs. The power-down sequence starts with `down_cmd` and is accepted only while the panel is on. It first waits a separate, longer interval of about two frame periods. It then sets the common voltage to zero and removes the rails in their own order.

`busy` is high while any sequence runs. `active` reports that the panel was last brought fully up.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset `busy`, `active`, `wr_valid` and `dac_req` are all 0.
- R2: Power-up issues these steps, each written as address←data: 6←1F, 3←03, 4←00, 4←04, 3←07, 6←09. It then issues one DAC step, then 3←17, 4←06, 6←01, 3←1F, 4←07, 6←00, then the phase write to address 1, then 7←00, then the resolution write to address 0.
- R3: The power-up DAC step uses base 0x04. Its value is the captured common-voltage setting, or 125 (0x7D) when that setting is zero.
- R4: The phase byte is 0x13 in quarter mode (`up_qvga`=1). In full mode it is {3'b000, phase, 1'b1} when `phase_ok`=1, and 0x01 otherwise.
- R5: The last power-up write goes to address 0, with data 0x01 in quarter mode and 0x00 in full mode.
- R6: After an accepted `down_cmd`, no request appears for at least FRAME_WAIT cycles. The steps are then 4←06, 6←08, 3←14, a DAC step, 4←04, 3←04, 6←1E, 3←00, 4←00.
- R7: The power-down DAC step has base 0x14 and value 0x00.
- R8: A request holds its address, data, base and value unchanged until its handshake completes. `wr_valid` and `dac_req` are never high together.
- R9: After a handshake completes, the next request rises no sooner than STEP_GAP+1 cycles later.
- R10: Commands that arrive while `busy` is high are ignored. A `down_cmd` while `active` is 0 issues nothing and leaves `busy` low.
- R11: If `up_cmd` and `down_cmd` arrive together while idle, power-down runs when `active` is 1 and power-up runs otherwise.
- R12: `active` becomes 1 when power-up completes and 0 when power-down completes. It does not change while idle, and `busy` stays high from command to last step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_cmd | input | 1 | Start power-up |
| up_qvga | input | 1 | Mode captured with up_cmd: 1 quarter, 0 full resolution |
| phase_val | input | 4 | Phase value for full mode |
| phase_ok | input | 1 | phase_val is valid |
| comv_set | input | 8 | Common-voltage setting, 0 selects the default |
| down_cmd | input | 1 | Start power-down |
| wr_addr | output | 3 | Register address |
| wr_data | output | 8 | Register data |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Write accepted |
| dac_req | output | 1 | DAC load request |
| dac_base | output | 8 | Base byte for the DAC transfer |
| dac_value | output | 8 | DAC value |
| dac_done | input | 1 | DAC load finished |
| busy | output | 1 | A sequence is running |
| active | output | 1 | Panel is powered up |

## Verification
Two things can happen in the same cycle: the two start commands can arrive together while the block is idle, and either command can arrive while a sequence is already running. The bench raises both commands on one cycle, once with the panel on and once with it off. It judges which sequence ran from the full logged list of transactions and from the final `active`. It also pulses both commands in the middle of a running power-up, then checks that the log still matches the mode captured at the start.

// File: rtl/pps_pkg.sv
package pps_pkg;
    typedef enum logic [1:0] {S_IDLE, S_FRAME, S_ISSUE, S_GAP} seq_state_e;
    typedef enum logic {DIR_UP, DIR_DOWN} seq_dir_e;

    typedef struct packed {
        logic       is_dac;
        logic [2:0] addr;
        logic [7:0] data;
        logic [7:0] base;
        logic       last;
    } step_t;

    localparam int UP_STEPS = 16;
    localparam int DN_STEPS = 9;
    localparam int IDX_W    = $clog2(UP_STEPS);

    localparam logic [2:0] RG_RES   = 3'd0;
    localparam logic [2:0] RG_PHASE = 3'd1;
    localparam logic [2:0] RG_PWR0  = 3'd3;
    localparam logic [2:0] RG_PWR1  = 3'd4;
    localparam logic [2:0] RG_PIF   = 3'd6;
    localparam logic [2:0] RG_POL   = 3'd7;

    localparam logic [7:0] COMV_FALLBACK = 8'd125;
    localparam logic [3:0] QVGA_PHASE    = 4'd9;
endpackage

// File: rtl/pps_timer.sv
module pps_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R9: a nonzero load leaves the timer running on the next cycle
    a_r9_timer_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !expired);
endmodule

// File: rtl/pps_step_rom.sv
module pps_step_rom
    import pps_pkg::*;
(
    input  seq_dir_e         dir,
    input  logic [IDX_W-1:0] idx,
    input  logic             qvga,
    input  logic [3:0]       phase,
    input  logic             phase_ok,
    input  logic [7:0]       comv,
    output step_t            step
);
    function automatic step_t wr(input logic [2:0] a, input logic [7:0] d);
        step_t s;
        s = '0;
        s.addr = a;
        s.data = d;
        return s;
    endfunction

    function automatic step_t dac(input logic [7:0] b, input logic [7:0] v);
        step_t s;
        s = '0;
        s.is_dac = 1'b1;
        s.base   = b;
        s.data   = v;
        return s;
    endfunction

    logic [7:0] phase_byte;
    logic [7:0] comv_eff;

    always_comb begin
        if (qvga)          phase_byte = {3'b000, QVGA_PHASE, 1'b1};
        else if (phase_ok) phase_byte = {3'b000, phase, 1'b1};
        else               phase_byte = 8'h01;
        comv_eff = (comv == 8'h00) ? COMV_FALLBACK : comv;
    end

    always_comb begin
        step = '0;
        if (dir == DIR_UP) begin
            unique case (idx)
                4'd0:  step = wr(RG_PIF,  8'h1F);
                4'd1:  step = wr(RG_PWR0, 8'h03);
                4'd2:  step = wr(RG_PWR1, 8'h00);
                4'd3:  step = wr(RG_PWR1, 8'h04);
                4'd4:  step = wr(RG_PWR0, 8'h07);
                4'd5:  step = wr(RG_PIF,  8'h09);
                4'd6:  step = dac(8'h04, comv_eff);
                4'd7:  step = wr(RG_PWR0, 8'h17);
                4'd8:  step = wr(RG_PWR1, 8'h06);
                4'd9:  step = wr(RG_PIF,  8'h01);
                4'd10: step = wr(RG_PWR0, 8'h1F);
                4'd11: step = wr(RG_PWR1, 8'h07);
                4'd12: step = wr(RG_PIF,  8'h00);
                4'd13: step = wr(RG_PHASE, phase_byte);
                4'd14: step = wr(RG_POL,  8'h00);
                default: step = wr(RG_RES, {7'b0, qvga});
            endcase
            step.last = (idx == IDX_W'(UP_STEPS - 1));
        end else begin
            unique case (idx)
                4'd0:  step = wr(RG_PWR1, 8'h06);
                4'd1:  step = wr(RG_PIF,  8'h08);
                4'd2:  step = wr(RG_PWR0, 8'h14);
                4'd3:  step = dac(8'h14, 8'h00);
                4'd4:  step = wr(RG_PWR1, 8'h04);
                4'd5:  step = wr(RG_PWR0, 8'h04);
                4'd6:  step = wr(RG_PIF,  8'h1E);
                4'd7:  step = wr(RG_PWR0, 8'h00);
                default: step = wr(RG_PWR1, 8'h00);
            endcase
            step.last = (idx >= IDX_W'(DN_STEPS - 1));
        end
    end
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
    import pps_pkg::*;
#(
    parameter int STEP_GAP   = 16,
    parameter int FRAME_WAIT = 1_670_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       up_cmd,
    input  logic       up_qvga,
    input  logic [3:0] phase_val,
    input  logic       phase_ok,
    input  logic [7:0] comv_set,
    input  logic       down_cmd,
    output logic [2:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       wr_valid,
    input  logic       wr_ready,
    output logic       dac_req,
    output logic [7:0] dac_base,
    output logic [7:0] dac_value,
    input  logic       dac_done,
    output logic       busy,
    output logic       active
);
    localparam int MAXW = (FRAME_WAIT > STEP_GAP) ? FRAME_WAIT : STEP_GAP;
    localparam int CW   = $clog2(MAXW + 1);

    typedef struct packed {
        seq_state_e       state;
        seq_dir_e         dir;
        logic [IDX_W-1:0] idx;
        logic             qvga;
        logic [3:0]       phase;
        logic             phase_ok;
        logic [7:0]       comv;
        logic             active;
    } seq_t;

    seq_t          seq_d, seq_q;
    step_t         step;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;
    logic          hs_done;

    pps_step_rom u_rom (
        .dir      (seq_q.dir),
        .idx      (seq_q.idx),
        .qvga     (seq_q.qvga),
        .phase    (seq_q.phase),
        .phase_ok (seq_q.phase_ok),
        .comv     (seq_q.comv),
        .step     (step)
    );

    pps_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    assign hs_done = step.is_dac ? dac_done : wr_ready;

    always_comb begin
        seq_d    = seq_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (seq_q.state)
            S_IDLE: begin
                if (down_cmd && seq_q.active) begin
                    seq_d.state = S_FRAME;
                    seq_d.dir   = DIR_DOWN;
                    seq_d.idx   = '0;
                    tmr_load    = 1'b1;
                    tmr_val     = CW'(FRAME_WAIT);
                end else if (up_cmd) begin
                    seq_d.state    = S_ISSUE;
                    seq_d.dir      = DIR_UP;
                    seq_d.idx      = '0;
                    seq_d.qvga     = up_qvga;
                    seq_d.phase    = phase_val;
                    seq_d.phase_ok = phase_ok;
                    seq_d.comv     = comv_set;
                end
            end
            S_FRAME: begin
                if (tmr_expired) seq_d.state = S_ISSUE;
            end
            S_ISSUE: begin
                if (hs_done) begin
                    seq_d.state = S_GAP;
                    tmr_load    = 1'b1;
                    tmr_val     = CW'(STEP_GAP);
                end
            end
            default: begin
                if (tmr_expired) begin
                    if (step.last) begin
                        seq_d.state  = S_IDLE;
                        seq_d.active = (seq_q.dir == DIR_UP);
                    end else begin
                        seq_d.state = S_ISSUE;
                        seq_d.idx   = seq_q.idx + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= S_IDLE;
            seq_q.dir   <= DIR_UP;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign wr_valid  = (seq_q.state == S_ISSUE) && !step.is_dac;
    assign dac_req   = (seq_q.state == S_ISSUE) &&  step.is_dac;
    assign wr_addr   = step.addr;
    assign wr_data   = step.data;
    assign dac_base  = step.base;
    assign dac_value = step.data;
    assign busy      = (seq_q.state != S_IDLE);
    assign active    = seq_q.active;

    // R8: write request held stable until accepted
    a_r8_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R8: DAC request held stable until done
    a_r8_dac_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_req && !dac_done) |=> (dac_req && $stable(dac_base) && $stable(dac_value)));

    // R8: never two requests at once
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && dac_req));

    // R9: a completed handshake is followed by a quiet cycle
    a_r9_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_valid && wr_ready) || (dac_req && dac_done)) |=> (!wr_valid && !dac_req));

    // R12: requests only while busy, and active steady while idle
    a_r12_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid || dac_req) |-> busy);
    a_r12_active_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(active));

    // R10: power-down ignored while the panel is off
    a_r10_down_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !active && down_cmd && !up_cmd) |=> !busy);
endmodule

// File: tb/panel_pwr_seq_tb.sv
module panel_pwr_seq_tb;
    localparam int GAP   = 3;
    localparam int FRAME = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       up_cmd = 1'b0, up_qvga = 1'b0, phase_ok = 1'b0, down_cmd = 1'b0;
    logic [3:0] phase_val = '0;
    logic [7:0] comv_set = '0;
    logic [2:0] wr_addr;
    logic [7:0] wr_data, dac_base, dac_value;
    logic       wr_valid, dac_req, busy, active;
    logic       wr_ready = 1'b0, dac_done = 1'b0;

    always #10 clk = ~clk;

    panel_pwr_seq #(.STEP_GAP(GAP), .FRAME_WAIT(FRAME)) u_dut (
        .clk(clk), .rst_n(rst_n), .up_cmd(up_cmd), .up_qvga(up_qvga),
        .phase_val(phase_val), .phase_ok(phase_ok), .comv_set(comv_set),
        .down_cmd(down_cmd), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .dac_req(dac_req),
        .dac_base(dac_base), .dac_value(dac_value), .dac_done(dac_done),
        .busy(busy), .active(active)
    );

    int checks = 0;
    int errors = 0;

    // {qvga, phase_ok, phase[3:0], comv[7:0]}
    localparam logic [13:0] VEC [0:3] = '{
        {1'b0, 1'b1, 4'hA, 8'h40},
        {1'b1, 1'b1, 4'h5, 8'h00},
        {1'b0, 1'b0, 4'h7, 8'h00},
        {1'b0, 1'b1, 4'hF, 8'hFF}
    };

    logic [16:0] log_e [0:31];
    int log_n = 0;
    int cyc = 0;
    int last_done = 0;
    int first_req = -1;
    int cmd_cyc = 0;
    bit seq_first = 1'b1;
    bit req_prev = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // responder: pseudo-random ready/done
    always @(negedge clk) begin
        lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        wr_ready <= lfsr[0];
        dac_done <= lfsr[3];
    end

    // monitor: logs transactions, checks step spacing
    always @(posedge clk) begin
        bit req_now;
        cyc++;
        req_now = wr_valid || dac_req;
        if (req_now && !req_prev) begin
            if (seq_first) begin
                first_req = cyc;
                seq_first = 1'b0;
            end else begin
                chk(cyc - last_done >= GAP + 1, "R9 step gap", cyc - last_done, GAP + 1);
            end
        end
        if (wr_valid && wr_ready && log_n < 32) begin
            log_e[log_n] = {1'b0, 5'b0, wr_addr, wr_data};
            log_n++;
            last_done = cyc;
        end
        if (dac_req && dac_done && log_n < 32) begin
            log_e[log_n] = {1'b1, dac_base, dac_value};
            log_n++;
            last_done = cyc;
        end
        req_prev = req_now;
    end

    function automatic logic [16:0] w(input logic [2:0] a, input logic [7:0] d);
        return {1'b0, 5'b0, a, d};
    endfunction

    function automatic logic [16:0] exp_step(input bit dn, input int i, input bit q,
                                             input logic [3:0] ph, input bit ok,
                                             input logic [7:0] cv);
        logic [7:0] pb;
        pb = q ? 8'h13 : (ok ? {3'b0, ph, 1'b1} : 8'h01);
        if (!dn) begin
            case (i)
                0: return w(6, 8'h1F);  1: return w(3, 8'h03);
                2: return w(4, 8'h00);  3: return w(4, 8'h04);
                4: return w(3, 8'h07);  5: return w(6, 8'h09);
                6: return {1'b1, 8'h04, (cv == 0) ? 8'd125 : cv};
                7: return w(3, 8'h17);  8: return w(4, 8'h06);
                9: return w(6, 8'h01); 10: return w(3, 8'h1F);
                11: return w(4, 8'h07); 12: return w(6, 8'h00);
                13: return w(1, pb);   14: return w(7, 8'h00);
                default: return w(0, {7'b0, q});
            endcase
        end
        case (i)
            0: return w(4, 8'h06); 1: return w(6, 8'h08);
            2: return w(3, 8'h14); 3: return {1'b1, 8'h14, 8'h00};
            4: return w(4, 8'h04); 5: return w(3, 8'h04);
            6: return w(6, 8'h1E); 7: return w(3, 8'h00);
            default: return w(4, 8'h00);
        endcase
    endfunction

    task automatic check_log(input bit dn, input bit q, input logic [3:0] ph,
                             input bit ok, input logic [7:0] cv, input string req);
        int n;
        n = dn ? 9 : 16;
        chk(log_n == n, {req, " step count"}, log_n, n);
        for (int i = 0; i < n && i < log_n; i++) begin
            logic [16:0] e;
            e = exp_step(dn, i, q, ph, ok, cv);
            chk(log_e[i] == e, $sformatf("%s step %0d", req, i), log_e[i], e);
        end
    endtask

    task automatic wait_idle();
        int t;
        t = 0;
        while (busy && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk(!busy, "R12 sequence ends", busy, 0);
    endtask

    task automatic start(input bit up, input bit dn, input bit q, input logic [3:0] ph,
                         input bit ok, input logic [7:0] cv);
        @(negedge clk);
        log_n = 0;
        seq_first = 1'b1;
        up_qvga = q; phase_val = ph; phase_ok = ok; comv_set = cv;
        up_cmd = up; down_cmd = dn;
        @(posedge clk);
        #1 cmd_cyc = cyc;
        @(negedge clk);
        up_cmd = 1'b0; down_cmd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !active, "R1 status after reset", {busy, active}, 0);
        chk(!wr_valid && !dac_req, "R1 requests after reset", {wr_valid, dac_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table walk: up then down for each vector (R2 R3 R4 R5 R6 R7 R12)
        for (int v = 0; v < 4; v++) begin
            logic [13:0] t;
            t = VEC[v];
            start(1'b1, 1'b0, t[13], t[11:8], t[12], t[7:0]);
            chk(busy, "R12 busy after up", busy, 1);
            wait_idle();
            check_log(1'b0, t[13], t[11:8], t[12], t[7:0], "R2 R3 R4 R5 power-up");
            chk(active, "R12 active after up", active, 1);
            start(1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00);
            wait_idle();
            check_log(1'b1, 1'b0, 4'h0, 1'b0, 8'h0, "R6 R7 power-down");
            chk(first_req - cmd_cyc >= FRAME, "R6 frame wait", first_req - cmd_cyc, FRAME);
            chk(!active, "R12 inactive after down", active, 0);
        end

        // R10: power-down while off does nothing
        start(1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 8'h0);
        repeat (60) @(negedge clk);
        chk(!busy && log_n == 0, "R10 down while off", log_n, 0);

        // R10: commands during a running power-up are ignored
        start(1'b1, 1'b0, 1'b0, 4'h3, 1'b1, 8'h20);
        repeat (30) @(negedge clk);
        up_cmd = 1'b1; down_cmd = 1'b1; up_qvga = 1'b1; comv_set = 8'h55;
        @(negedge clk);
        up_cmd = 1'b0; down_cmd = 1'b0;
        wait_idle();
        check_log(1'b0, 1'b0, 4'h3, 1'b1, 8'h20, "R10 ignore while busy");
        chk(active, "R10 still on", active, 1);

        // R11: both commands while on -> power-down
        start(1'b1, 1'b1, 1'b1, 4'h0, 1'b0, 8'h0);
        wait_idle();
        check_log(1'b1, 1'b0, 4'h0, 1'b0, 8'h0, "R11 both while on");
        chk(!active, "R11 off after both", active, 0);

        // R11: both commands while off -> power-up
        start(1'b1, 1'b1, 1'b1, 4'h2, 1'b1, 8'h09);
        wait_idle();
        check_log(1'b0, 1'b1, 4'h2, 1'b1, 8'h09, "R11 both while off");
        chk(active, "R11 on after both", active, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule